// File: doc/BRIEF.md
# Latched 64-bit Match Timer

A system timer peripheral on a simple 32-bit register bus. A 64-bit up-counter advances once per prescaler tick. The tick period is twice the programmed divide value plus one, in input clocks. Software can overwrite either half of the running count. Because a 64-bit value cannot be read in one bus access, software reads the count through a snapshot: a command write copies the whole live count into two read-only words in one cycle, so the halves always agree.

Six 32-bit comparators watch the low word of the count. The low word wraps at 2^32, so the compares wrap too. A comparator fires when an increment moves the low word onto its value. Each firing sets a sticky status bit, which software clears by writing 1 to it. A per-bit enable passes each status bit to its own interrupt line. The last comparator doubles as a watchdog: when the watchdog enable is set, its status bit also drives a reset-request output.

Top module: `match_timer`

Register words, at byte offset = 4 × index: 0 count low, 1 count high, 2..7 compare 0..5, 8 status, 9 interrupt enable, 10 watchdog enable, 11 divider, 12 snapshot command, 13 snapshot low, 14 snapshot high.

## Requirements
- R1: After reset, the count, snapshot, compare values, status, interrupt enable, watchdog enable and divider all read zero, and every output is low.
- R2: With divider N (word 11), the count advances once every 2(N+1) clocks. Writing the divider restarts the tick phase, so the first advance after the write comes 2(N+1) clocks later.
- R3: A write to word 0 or word 1 replaces that half of the count. In a cycle where a tick also falls, the written half takes the written value and the other half takes its incremented value.
- R4: When an increment moves the low word from all ones to zero, the high word advances by one.
- R5: Writing word 12 with bit 0 set copies the count as it stood before that edge into the snapshot words 13 (low) and 14 (high). A write to word 12 with bit 0 clear changes nothing, and word 12 reads zero.
- R6: Status bit n (word 8, bits 5:0) is set on the edge where an increment makes the low count equal to compare value n. A software load onto that value does not set it.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new match on the same bit fall in one cycle, the bit stays set.
- R8: Interrupt output n is high exactly while status bit n and enable bit n (word 9, bits 5:0) are both set.
- R9: The watchdog output is high exactly while status bit 5 and watchdog enable bit 0 (word 10) are both set.
- R10: An offset with its two low bits nonzero, and word 15, are unmapped. Writes to them change nothing and reads return zero. Unused upper bits of status, enable and watchdog-enable words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 6 | Per-comparator interrupt lines |
| wdog_rst_o | output | 1 | Watchdog reset request |

## Verification
Two pairs of events can fall in the same cycle. A software write to a count half can meet a prescaler tick, and a status-clear write can meet a fresh match on the same bit. With the divider at zero, every other cycle carries a tick. The bench therefore writes count halves on back-to-back cycles, and repeats clear writes on every cycle while the count sweeps across a compare value, so both coincidences occur. A behavioural reference model is updated on every edge from the same bus inputs and decides the expected outcome, which is compared with the read data, the interrupts and the watchdog output on every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CMP  = 6;
  localparam int WDOG_IDX = NUM_CMP - 1;
  localparam int ADDR_W   = 6;
  localparam int WIDX_W   = ADDR_W - 2;

  localparam logic [WIDX_W-1:0] W_CNT_LO = 4'd0;
  localparam logic [WIDX_W-1:0] W_CNT_HI = 4'd1;
  localparam logic [WIDX_W-1:0] W_CMP0   = 4'd2;
  localparam logic [WIDX_W-1:0] W_STATUS = 4'd8;
  localparam logic [WIDX_W-1:0] W_IEN    = 4'd9;
  localparam logic [WIDX_W-1:0] W_WDEN   = 4'd10;
  localparam logic [WIDX_W-1:0] W_DIV    = 4'd11;
  localparam logic [WIDX_W-1:0] W_SNAP   = 4'd12;
  localparam logic [WIDX_W-1:0] W_SNAPLO = 4'd13;
  localparam logic [WIDX_W-1:0] W_SNAPHI = 4'd14;

  // last phase value of a prescale period: 2*(div+1) - 1
  function automatic logic [DATA_W:0] prescale_last(input logic [DATA_W-1:0] div);
    return {div, 1'b1};
  endfunction

  // full-width increment of the count by one tick
  function automatic logic [2*DATA_W-1:0] count_step(input logic [2*DATA_W-1:0] cnt,
                                                      input logic tick);
    return cnt + {{(2*DATA_W-1){1'b0}}, tick};
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             tick_o
);
  logic [DIV_W:0] phase_q;

  assign tick_o = (phase_q == {div_q, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (div_wr) begin
      div_q   <= div_wdata;
      phase_q <= '0;
    end else if (tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // at least two clocks lie between ticks
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/count64.sv
module count64 #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] cnt_q,
  output logic [HALF_W-1:0]   inc_lo,
  output logic                lo_step
);
  import timer_pkg::*;
  logic [2*HALF_W-1:0] stepped;

  assign stepped = count_step(cnt_q, tick_i);
  assign inc_lo  = stepped[HALF_W-1:0];
  assign lo_step = tick_i & ~wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q[HALF_W-1:0]        <= wr_lo ? wdata : stepped[HALF_W-1:0];
      cnt_q[2*HALF_W-1:HALF_W] <= wr_hi ? wdata : stepped[2*HALF_W-1:HALF_W];
    end
  end

  assert_hold_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_lo && !wr_hi && (&cnt_q[HALF_W-1:0]))
      |=> (cnt_q[2*HALF_W-1:HALF_W] == $past(cnt_q[2*HALF_W-1:HALF_W]) + 1'b1));

  assert_sw_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/match_bank.sv
module match_bank #(
  parameter int N = 6,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [W-1:0]        wdata,
  input  logic                step_i,
  input  logic [W-1:0]        inc_lo,
  output logic [N-1:0][W-1:0] cmp_q,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q[g] <= '0;
      else if (wr_en[g]) cmp_q[g] <= wdata;
    end
    assign hit_o[g] = step_i && (inc_lo == cmp_q[g]);
  end

  assert_hit_needs_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o != '0) |-> step_i);
endmodule

// File: rtl/match_timer.sv
module match_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [5:0]  irq_o,
  output logic        wdog_rst_o
);
  import timer_pkg::*;

  logic [WIDX_W-1:0]              wsel;
  logic                           wr;
  logic                           wr_lo, wr_hi, wr_div, wr_st, wr_ien, wr_wden, snap_cmd;
  logic [NUM_CMP-1:0]             wr_cmp;
  logic                           tick;
  logic [DATA_W-1:0]              div_q;
  logic [2*DATA_W-1:0]            cnt_q;
  logic [DATA_W-1:0]              inc_lo;
  logic                           lo_step;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_q;
  logic [NUM_CMP-1:0]             hit;
  logic [NUM_CMP-1:0]             status_q, ien_q, clr;
  logic                           wden_q;
  logic [2*DATA_W-1:0]            snap_q;

  assign wsel     = bus_addr[ADDR_W-1:2];
  assign wr       = bus_we && (bus_addr[1:0] == 2'b00);
  assign wr_lo    = wr && (wsel == W_CNT_LO);
  assign wr_hi    = wr && (wsel == W_CNT_HI);
  assign wr_div   = wr && (wsel == W_DIV);
  assign wr_st    = wr && (wsel == W_STATUS);
  assign wr_ien   = wr && (wsel == W_IEN);
  assign wr_wden  = wr && (wsel == W_WDEN);
  assign snap_cmd = wr && (wsel == W_SNAP) && bus_wdata[0];

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmpsel
    assign wr_cmp[g] = wr && (wsel == W_CMP0 + WIDX_W'(g));
  end

  tick_prescaler #(.DIV_W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_wr(wr_div), .div_wdata(bus_wdata),
    .div_q(div_q), .tick_o(tick));

  count64 #(.HALF_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .cnt_q(cnt_q), .inc_lo(inc_lo), .lo_step(lo_step));

  match_bank #(.N(NUM_CMP), .W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmp), .wdata(bus_wdata),
    .step_i(lo_step), .inc_lo(inc_lo), .cmp_q(cmp_q), .hit_o(hit));

  assign clr = wr_st ? bus_wdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      wden_q   <= 1'b0;
      snap_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr) | hit;
      if (wr_ien)   ien_q  <= bus_wdata[NUM_CMP-1:0];
      if (wr_wden)  wden_q <= bus_wdata[0];
      if (snap_cmd) snap_q <= cnt_q;
    end
  end

  assign irq_o      = status_q & ien_q;
  assign wdog_rst_o = status_q[WDOG_IDX] & wden_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      case (wsel)
        W_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
        W_CNT_HI: bus_rdata = cnt_q[2*DATA_W-1:DATA_W];
        W_STATUS: bus_rdata = {{(DATA_W-NUM_CMP){1'b0}}, status_q};
        W_IEN:    bus_rdata = {{(DATA_W-NUM_CMP){1'b0}}, ien_q};
        W_WDEN:   bus_rdata = {{(DATA_W-1){1'b0}}, wden_q};
        W_DIV:    bus_rdata = div_q;
        W_SNAPLO: bus_rdata = snap_q[DATA_W-1:0];
        W_SNAPHI: bus_rdata = snap_q[2*DATA_W-1:DATA_W];
        default: begin
          for (int i = 0; i < NUM_CMP; i++)
            if (wsel == W_CMP0 + WIDX_W'(i)) bus_rdata = cmp_q[i];
        end
      endcase
    end
  end

  assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hit) != '0) |=> ((status_q & $past(clr & ~hit)) == '0));

  assert_wdog_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> status_q[WDOG_IDX]);

  assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cmd |=> (snap_q == $past(cnt_q)));

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~status_q) == '0);
endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_o;
  logic        wdog_rst_o;

  match_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o));

  always #4 clk = ~clk;

  int    checks = 0, fails = 0, cycles = 0;
  bit    cmp_on = 0;
  string phase = "R1";

  // reference model state
  logic [63:0] m_cnt, m_snap;
  longint      m_pc;
  logic [31:0] m_div;
  logic [31:0] m_cmp [6];
  logic [5:0]  m_st, m_ien;
  logic        m_wden;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    int w = int'(a) / 4;
    if (a % 4 != 0) return 0;
    case (w)
      0: return m_cnt[31:0];
      1: return m_cnt[63:32];
      2, 3, 4, 5, 6, 7: return m_cmp[w-2];
      8: return {26'd0, m_st};
      9: return {26'd0, m_ien};
      10: return {31'd0, m_wden};
      11: return m_div;
      13: return m_snap[31:0];
      14: return m_snap[63:32];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    int w = int'(a) / 4;
    if (a % 4 != 0 || w == 15) return "R10";
    if (w < 2) return "R3";
    if (w < 8) return "R6";
    case (w)
      8: return "R7";
      9: return "R8";
      10: return "R9";
      11: return "R2";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_pc = 0; m_div = 0; m_st = 0; m_ien = 0; m_wden = 0;
      for (int i = 0; i < 6; i++) m_cmp[i] = 0;
      cmp_on = 1;
    end else begin
      bit tk, ok, snap;
      int w;
      logic [63:0] nx;
      logic [5:0] h;
      ok = bus_we && (bus_addr % 4 == 0);
      w  = int'(bus_addr) / 4;
      tk = (m_pc == 2 * longint'(m_div) + 1);
      snap = ok && w == 12 && bus_wdata[0];
      nx = m_cnt + (tk ? 64'd1 : 64'd0);
      h = 0;
      for (int i = 0; i < 6; i++)
        if (tk && !(ok && w == 0) && nx[31:0] == m_cmp[i]) h[i] = 1;
      m_pc = tk ? 0 : m_pc + 1;
      if (snap) m_snap = m_cnt;
      if (ok && w == 0) nx[31:0] = bus_wdata;
      if (ok && w == 1) nx[63:32] = bus_wdata;
      if (ok && w == 8) m_st = m_st & ~bus_wdata[5:0];
      m_st = m_st | h;
      if (ok && w == 9) m_ien = bus_wdata[5:0];
      if (ok && w == 10) m_wden = bus_wdata[0];
      if (ok && w == 11) begin m_div = bus_wdata; m_pc = 0; end
      if (ok && w >= 2 && w <= 7) m_cmp[w-2] = bus_wdata;
      m_cnt = nx;
    end
  end

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) at cycle %0d: got %h expected %h", t, phase, cycles, got, exp);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R8", {26'd0, irq_o}, {26'd0, m_st & m_ien});
      chk("R9", {31'd0, wdog_rst_o}, {31'd0, m_st[5] & m_wden});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bus_we = 0; bus_addr = a; end
  endtask

  initial begin
    // R1 reset state and R10 unmapped reads
    repeat (3) @(negedge clk);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); bus_addr = 6'(a);
    end
    rst_n = 1;
    phase = "R10";
    for (int a = 60; a < 64; a++) rd(6'(a), 1);
    wr(6'h3C, 32'hFFFF_FFFF); wr(6'h09, 32'h3F); rd(6'h24, 2); rd(6'h3C, 2);
    // R2 prescaler rates
    phase = "R2";
    rd(6'h00, 20);
    wr(6'h2C, 3); rd(6'h00, 40);
    wr(6'h2C, 1); rd(6'h00, 8); wr(6'h2C, 1); rd(6'h00, 12);
    wr(6'h2C, 0);
    // R3 load coinciding with ticks, back to back
    phase = "R3";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bus_we = 1; bus_addr = 6'(4 * (i % 2)); bus_wdata = 32'h1000 + 32'(i);
    end
    @(negedge clk); bus_we = 0; rd(6'h04, 3);
    // R4 carry across the low word
    phase = "R4";
    wr(6'h04, 32'h0000_0007); wr(6'h00, 32'hFFFF_FFFC); rd(6'h04, 14); rd(6'h00, 4);
    // R5 snapshot
    phase = "R5";
    wr(6'h30, 1); rd(6'h34, 2); rd(6'h38, 2);
    rd(6'h00, 5); wr(6'h30, 2); rd(6'h34, 2); rd(6'h30, 1);
    wr(6'h30, 32'h8000_0001); rd(6'h38, 1); rd(6'h34, 1);
    // R6 matches, load onto a compare value does not hit
    phase = "R6";
    wr(6'h24, 6'h3F);
    for (int i = 0; i < 6; i++) wr(6'(8 + 4 * i), m_cnt[31:0] + 32'(10 + 2 * i));
    rd(6'h20, 30);
    wr(6'h20, 6'h3F); wr(6'h08, 32'h0000_5000); wr(6'h00, 32'h0000_5000); rd(6'h20, 4);
    // R7 clear racing a new match
    phase = "R7";
    wr(6'h20, 0); wr(6'h0C, m_cnt[31:0] + 32'd8);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); bus_we = 1; bus_addr = 6'h20; bus_wdata = 32'h02;
    end
    @(negedge clk); bus_we = 0; rd(6'h20, 2);
    // R9 watchdog
    phase = "R9";
    wr(6'h28, 1); wr(6'h1C, m_cnt[31:0] + 32'd6); rd(6'h20, 10);
    wr(6'h28, 0); rd(6'h28, 2); wr(6'h28, 1); wr(6'h20, 6'h20); rd(6'h20, 2);
    // mixed traffic
    phase = "mix";
    for (int i = 0; i < 3000; i++) begin
      int w;
      @(negedge clk);
      w = $urandom_range(0, 15);
      bus_we = ($urandom_range(0, 3) == 0);
      bus_addr = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(0, 63)) : 6'(4 * w);
      case (w)
        0: bus_wdata = ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 15))
                                                   : $urandom;
        2, 3, 4, 5, 6, 7: bus_wdata = m_cnt[31:0] + 32'($urandom_range(1, 12));
        11: bus_wdata = 32'($urandom_range(0, 3));
        default: bus_wdata = $urandom;
      endcase
    end
    @(negedge clk); bus_we = 0;
    rd(6'h20, 4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer than 200000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule